// File: doc/BRIEF.md
# Bus Source-Tagged Capture Monitor

This block sits beside a multiplexed external local bus and only listens. On each rising clock edge it samples a 5-bit source tag, an address-latch strobe, a data-valid strobe, 16 shared address/data lines and 10 dedicated upper address lines. It never drives any bus signal. The all-ones tag value means nothing useful is on the bus. Any other tag value names the requester that owns the current phase.

When the tag is valid and the address-latch strobe is high, the block stores a 26-bit address. The shared lines form the upper 16 bits and the dedicated lines form the lower 10 bits. It also stores the tag seen with that address. When the tag is valid and the data-valid strobe is high, the block emits a record for one cycle. The record holds the tag, the stored address and the data word. It also carries two flags: one for "no address seen since reset" and one for "tag differs from the address owner". Debug or trace logic downstream takes the records whenever the record-valid pulse is high.

Top module: `srcid_capture_mon`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, all record outputs clear to zero and the stored address is marked absent.
- R2: An edge with `src_id` != 5'h1F and `ale_i` high stores the address {`bus_ad`, `bus_ahi`}. `bus_ad[15]` (shared line 0) becomes address bit 25, the most significant bit, and `bus_ahi[0]` becomes bit 0.
- R3: While `src_id` equals 5'h1F, both strobes have no effect. No record is emitted and the stored address and tag stay unchanged.
- R4: An edge with a valid `src_id` and `dval_i` high raises `rec_valid` for exactly the following cycle. In that cycle `rec_id` equals the sampled tag and `rec_data` equals the sampled `bus_ad`.
- R5: `rec_addr` of a record equals the most recently stored address, which stays valid across any number of later data captures.
- R6: A record with no address stored since reset has `rec_no_addr` = 1, `rec_addr` = 0 and `rec_id_mismatch` = 0.
- R7: `rec_id_mismatch` is 1 exactly when an address is stored and the record's tag differs from the tag stored with that address.
- R8: When both strobes are high on one valid edge, the record pairs the data with the address stored before that edge. The new address is then stored for later records.
- R9: Between records `rec_valid` is 0 and every other record output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_id | input | 5 | Source tag of the current bus phase; 5'h1F means idle/invalid |
| ale_i | input | 1 | Address-latch strobe (level, active high) |
| dval_i | input | 1 | Data-valid strobe (level, active high) |
| bus_ad | input | 16 | Shared address/data lines; bit 15 is line 0 (MSB) |
| bus_ahi | input | 10 | Dedicated address lines, lowest 10 address bits |
| rec_valid | output | 1 | One-cycle pulse marking a new record |
| rec_id | output | 5 | Source tag of the record |
| rec_addr | output | 26 | Stored address paired with the data |
| rec_data | output | 16 | Captured data word |
| rec_no_addr | output | 1 | No address had been stored since reset |
| rec_id_mismatch | output | 1 | Record tag differs from the stored address's tag |

## Verification
A corrupted stored address or owner tag stays hidden until the next data capture. It then shows up in that record's `rec_addr` or in a wrongly set or cleared flag in the cycle after the data strobe. A wrong qualification or pulse shape shows up one cycle after the offending edge, as an extra, missing or stretched `rec_valid`. The bench therefore applies address phases, idle-tag phases and data phases in many orders. It compares every output against a behavioural model on every cycle, so each error is reported in the cycle where it first becomes visible.

// File: rtl/srcid_mon_pkg.sv
// Package: shared widths for the source-tagged capture monitor.
// Assumes: the tag's all-ones value is the reserved idle code.
package srcid_mon_pkg;
    parameter int ID_W = 5;
    parameter int LO_W = 16;
    parameter int HI_W = 10;
    localparam int ADDR_W = LO_W + HI_W;
endpackage

// File: rtl/srcid_qualify.sv
// Module: srcid_qualify
// Turns raw strobes into capture enables. A strobe counts only when the
// tag is not the reserved all-ones idle code.
// Assumes: strobes are synchronous levels sampled by the consumer's clock.
module srcid_qualify #(
    parameter int ID_W = srcid_mon_pkg::ID_W
) (
    input  logic [ID_W-1:0] src_id,
    input  logic            ale_i,
    input  logic            dval_i,
    output logic            take_addr,
    output logic            take_data
);
    localparam logic [ID_W-1:0] IDLE_ID = {ID_W{1'b1}};

    logic tag_live;

    // Qualify both strobes with a live tag.
    always_comb begin
        tag_live  = (src_id != IDLE_ID);
        take_addr = tag_live && ale_i;
        take_data = tag_live && dval_i;
    end
endmodule

// File: rtl/srcid_addr_store.sv
// Module: srcid_addr_store
// Holds the last qualified address and the tag that owned it, and
// remembers whether any address has been stored since reset.
// Assumes: take_addr is already qualified; reset is synchronous, active low.
module srcid_addr_store #(
    parameter int ID_W = srcid_mon_pkg::ID_W,
    parameter int LO_W = srcid_mon_pkg::LO_W,
    parameter int HI_W = srcid_mon_pkg::HI_W,
    localparam int ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_addr,
    input  logic [ID_W-1:0]   src_id,
    input  logic [LO_W-1:0]   bus_ad,
    input  logic [HI_W-1:0]   bus_ahi,
    output logic [ADDR_W-1:0] held_addr,
    output logic [ID_W-1:0]   held_id,
    output logic              held_vld
);
    // Store address and owner tag on a qualified address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_id   <= '0;
            held_vld  <= 1'b0;
        end else if (take_addr) begin
            held_addr <= {bus_ad, bus_ahi};
            held_id   <= src_id;
            held_vld  <= 1'b1;
        end
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take_addr |=> (held_addr == $past({bus_ad, bus_ahi})) && held_vld); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_addr |=> $stable(held_addr) && $stable(held_id)); // R3
endmodule

// File: rtl/srcid_record.sv
// Module: srcid_record
// Builds the output record on a qualified data phase: tag, stored
// address, data word and the two consistency flags.
// Assumes: held_* reflect state before the current edge.
module srcid_record #(
    parameter int ID_W = srcid_mon_pkg::ID_W,
    parameter int LO_W = srcid_mon_pkg::LO_W,
    parameter int HI_W = srcid_mon_pkg::HI_W,
    localparam int ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_data,
    input  logic [ID_W-1:0]   src_id,
    input  logic [LO_W-1:0]   bus_ad,
    input  logic [ADDR_W-1:0] held_addr,
    input  logic [ID_W-1:0]   held_id,
    input  logic              held_vld,
    output logic              rec_valid,
    output logic [ID_W-1:0]   rec_id,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [LO_W-1:0]   rec_data,
    output logic              rec_no_addr,
    output logic              rec_id_mismatch
);
    // Emit a one-cycle record; payload holds until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid       <= 1'b0;
            rec_id          <= '0;
            rec_addr        <= '0;
            rec_data        <= '0;
            rec_no_addr     <= 1'b0;
            rec_id_mismatch <= 1'b0;
        end else begin
            rec_valid <= take_data;
            if (take_data) begin
                rec_id          <= src_id;
                rec_addr        <= held_addr;
                rec_data        <= bus_ad;
                rec_no_addr     <= !held_vld;
                rec_id_mismatch <= held_vld && (held_id != src_id);
            end
        end
    end

    AST_REC_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |=> rec_valid && (rec_data == $past(bus_ad)) && (rec_id == $past(src_id))); // R4
    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_data |=> !rec_valid && $stable(rec_addr) && $stable(rec_data)); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rec_no_addr |-> !rec_id_mismatch && (rec_addr == '0)); // R6
endmodule

// File: rtl/srcid_capture_mon.sv
// Module: srcid_capture_mon (top)
// Passive monitor of a multiplexed local bus. It stores tagged addresses
// and emits address/data records with consistency flags.
// Assumes: synchronous active-low reset; never drives any bus signal.
module srcid_capture_mon (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  src_id,
    input  logic        ale_i,
    input  logic        dval_i,
    input  logic [15:0] bus_ad,
    input  logic [9:0]  bus_ahi,
    output logic        rec_valid,
    output logic [4:0]  rec_id,
    output logic [25:0] rec_addr,
    output logic [15:0] rec_data,
    output logic        rec_no_addr,
    output logic        rec_id_mismatch
);
    import srcid_mon_pkg::*;

    logic              take_addr;
    logic              take_data;
    logic [ADDR_W-1:0] held_addr;
    logic [ID_W-1:0]   held_id;
    logic              held_vld;

    srcid_qualify #(.ID_W(ID_W)) u_qual (
        .src_id   (src_id),
        .ale_i    (ale_i),
        .dval_i   (dval_i),
        .take_addr(take_addr),
        .take_data(take_data)
    );

    srcid_addr_store #(.ID_W(ID_W), .LO_W(LO_W), .HI_W(HI_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_addr(take_addr),
        .src_id   (src_id),
        .bus_ad   (bus_ad),
        .bus_ahi  (bus_ahi),
        .held_addr(held_addr),
        .held_id  (held_id),
        .held_vld (held_vld)
    );

    srcid_record #(.ID_W(ID_W), .LO_W(LO_W), .HI_W(HI_W)) u_rec (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_data      (take_data),
        .src_id         (src_id),
        .bus_ad         (bus_ad),
        .held_addr      (held_addr),
        .held_id        (held_id),
        .held_vld       (held_vld),
        .rec_valid      (rec_valid),
        .rec_id         (rec_id),
        .rec_addr       (rec_addr),
        .rec_data       (rec_data),
        .rec_no_addr    (rec_no_addr),
        .rec_id_mismatch(rec_id_mismatch)
    );

    AST_IDLE_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (src_id == 5'h1F) |=> !rec_valid); // R3
    AST_MISMATCH_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rec_id_mismatch |-> !rec_no_addr && (rec_id != 5'h1F)); // R7
endmodule

// File: tb/test_srcid_capture_mon.sv
// Bench: drives bus phases on the falling edge, updates a behavioural
// model at each rising edge, and compares all outputs on the next falling edge.
module test_srcid_capture_mon;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_id = 5'h1F;
    logic        ale_i = 1'b0;
    logic        dval_i = 1'b0;
    logic [15:0] bus_ad = '0;
    logic [9:0]  bus_ahi = '0;
    logic        rec_valid;
    logic [4:0]  rec_id;
    logic [25:0] rec_addr;
    logic [15:0] rec_data;
    logic        rec_no_addr;
    logic        rec_id_mismatch;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Model state.
    bit          m_av;
    logic [25:0] m_addr;
    logic [4:0]  m_aid;
    bit          e_valid, e_noaddr, e_mis;
    logic [4:0]  e_id;
    logic [25:0] e_addr;
    logic [15:0] e_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    srcid_capture_mon i_srcid_capture_mon (
        .clk(clk), .rst_n(rst_n), .src_id(src_id), .ale_i(ale_i),
        .dval_i(dval_i), .bus_ad(bus_ad), .bus_ahi(bus_ahi),
        .rec_valid(rec_valid), .rec_id(rec_id), .rec_addr(rec_addr),
        .rec_data(rec_data), .rec_no_addr(rec_no_addr),
        .rec_id_mismatch(rec_id_mismatch)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_av = 0; m_addr = '0; m_aid = '0;
            e_valid = 0; e_id = '0; e_addr = '0; e_data = '0;
            e_noaddr = 0; e_mis = 0;
        end else begin
            bit live;
            live = (src_id != 5'h1F);
            e_valid = live && dval_i;
            if (e_valid) begin          // R8: uses address from before this edge
                e_id = src_id; e_addr = m_addr; e_data = bus_ad;
                e_noaddr = !m_av;
                e_mis = m_av && (m_aid != src_id);
            end
            if (live && ale_i) begin
                m_addr = {bus_ad, bus_ahi}; m_aid = src_id; m_av = 1;
            end
        end
    endtask

    task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    task automatic step(string tag, logic [4:0] id, bit a, bit d,
                        logic [15:0] ad, logic [9:0] hi);
        src_id = id; ale_i = a; dval_i = d; bus_ad = ad; bus_ahi = hi;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (done) return;
        vectors++;
        chk(tag, "rec_valid", 32'(rec_valid), 32'(e_valid));
        chk(tag, "rec_id", 32'(rec_id), 32'(e_id));
        chk(tag, "rec_addr", 32'(rec_addr), 32'(e_addr));
        chk(tag, "rec_data", 32'(rec_data), 32'(e_data));
        chk(tag, "rec_no_addr", 32'(rec_no_addr), 32'(e_noaddr));
        chk(tag, "rec_id_mismatch", 32'(rec_id_mismatch), 32'(e_mis));
    endtask

    task automatic idle(string tag);
        step(tag, 5'h1F, 0, 0, 16'hDEAD, 10'h155);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset with strobes active must still clear everything.
        rst_n = 0;
        step("R1", 5'h03, 1, 1, 16'hFFFF, 10'h3FF);
        step("R1", 5'h03, 1, 1, 16'h1234, 10'h2AA);
        rst_n = 1;
        idle("R1");
        // R6: data before any address.
        step("R6", 5'h04, 0, 1, 16'hA5A5, 10'h001);
        idle("R9");
        // R3: strobes under idle tag are ignored.
        step("R3", 5'h1F, 1, 1, 16'hBEEF, 10'h3C3);
        step("R3", 5'h1F, 0, 1, 16'h0F0F, 10'h000);
        step("R3", 5'h06, 0, 1, 16'h7777, 10'h000);
        // R2: address with MSB-first mapping, then data.
        step("R2", 5'h02, 1, 0, 16'h8001, 10'h201);
        idle("R9");
        step("R5", 5'h02, 0, 1, 16'h1111, 10'h0);
        step("R5", 5'h02, 0, 1, 16'h2222, 10'h0);
        step("R7", 5'h09, 0, 1, 16'h3333, 10'h0);
        // R3: idle-tag address phase must not overwrite stored address.
        step("R3", 5'h1F, 1, 0, 16'hFFFF, 10'h3FF);
        step("R3", 5'h02, 0, 1, 16'h4444, 10'h0);
        // R8: both strobes at once.
        step("R8", 5'h05, 1, 1, 16'hC0DE, 10'h0AB);
        step("R8", 5'h05, 0, 1, 16'h5555, 10'h0);
        step("R7", 5'h00, 0, 1, 16'h6666, 10'h0);
        idle("R9");
        idle("R9");
        // Pseudo-random phase mix.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [4:0] id;
            r = $urandom();
            id = (r[2:0] == 0) ? 5'h1F : {3'b0, r[4:3]};
            step("R4", id, r[5], r[6], r[22:7], r[31:22]);
        end
        idle("R9");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule